// File: doc/BRIEF.md
# Seven-to-one LVDS pixel serializer

This block turns a parallel video stream into the bit streams of a seven-slot LVDS link. One pixel enters per pixel period: 8-bit red, green and blue, plus horizontal sync, vertical sync and data enable. The block runs on the fast bit clock, which is seven times the pixel rate. On each fast clock it drives one bit on each of four data lanes and one bit on a clock lane. The clock lane carries a fixed 1100011 pattern that marks pixel boundaries at the receiver.

A two-bit map select picks how colour and control bits are spread over the slots. The three layouts are:
- a narrow 18-bit layout on three lanes;
- a 24-bit layout whose first three lanes carry the upper six bits of each colour, with lane 3 carrying the two low bits;
- a 24-bit layout whose first three lanes carry bits 5..0, with lane 3 carrying the two top bits.

Pixel and map select are both captured into a shadow register at each pixel boundary. Input changes therefore never disturb a word partway through transmission. Differential buffers, clock synthesis and deskew belong to the surrounding logic.

Top module: `lvds_pixel_serializer`

## Requirements
- R1: Slots are numbered 0..6, and slot 0 is sent first. The clock lane reads 1,1,0,0,0,1,1 over slots 0..6 and repeats every seven fast cycles, starting at slot 0 on the first rising edge after reset.
- R2: While reset is high, all outputs are 0. After reset the data lanes stay 0 for the first seven slots, until the first captured pixel is being sent.
- R3: The pixel inputs and map select are sampled on the 7th rising edge after reset and on every 7th edge after that. Slot s of that pixel appears on the lanes after the (s+1)-th following rising edge.
- R4: Changes to the pixel inputs or to map select between two capture edges have no effect on the word being sent.
- R5: Map select encoding: 2'b00 selects the narrow 18-bit layout, 2'b01 the 24-bit upper-bits layout, and 2'b10 the 24-bit low-bits-on-lane-3 layout. 2'b11 behaves exactly like 2'b00.
- R6: In narrow mode, writing R5..R0 for red[7:2] and likewise for green and blue, slots 0..6 carry the following. Lane 0: G0,R5,R4,R3,R2,R1,R0. Lane 1: B1,B0,G5,G4,G3,G2,G1. Lane 2: DE,VS,HS,B5,B4,B3,B2.
- R7: In narrow mode, lane 3 is held at 0, and bits [1:0] of each colour input are ignored.
- R8: In the 24-bit upper-bits mode, slots 0..6 carry the following. Lane 0: g2,r7,r6,r5,r4,r3,r2. Lane 1: b3,b2,g7..g3. Lane 2: DE,VS,HS,b7,b6,b5,b4. Lane 3: 0,b1,b0,g1,g0,r1,r0.
- R9: In the 24-bit low-bits mode, lanes 0..2 use the narrow layout with colour bits [5:0] in place of [7:2]. Slots 0..6 of lane 3 carry 0,b7,b6,g7,g6,r7,r6.
- R10: Horizontal sync sits in lane 2 slot 2, vertical sync in lane 2 slot 1 and data enable in lane 2 slot 0. Lane 3 slot 0 is 0 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock, seven cycles per pixel |
| rst | input | 1 | Synchronous active-high reset |
| pix_red | input | 8 | Red component |
| pix_green | input | 8 | Green component |
| pix_blue | input | 8 | Blue component |
| pix_hsync | input | 1 | Horizontal sync |
| pix_vsync | input | 1 | Vertical sync |
| pix_de | input | 1 | Data enable |
| map_sel | input | 2 | Lane layout select, sampled at pixel boundaries |
| lane_dat | output | 4 | Serial data lanes 0..3 |
| lane_clk | output | 1 | Clock lane pattern |

## Verification
The bench builds the block with its default package constants: seven slots, four lanes and 8-bit colour. These are the only values the three layouts define, so every slot of every lane is reachable, including lane 3 in all four map select codes. Directed pixels use walking and alternating bit patterns, so that any swapped slot or lane shows as a mismatch. Other pixels differ only in their two low colour bits, which narrow mode must hide. One scenario changes map select and the pixel inputs in the middle of a word to confirm that the shadow capture holds.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;

    localparam int SLOTS   = 7;
    localparam int LANES   = 4;
    localparam int COLOR_W = 8;
    localparam int CNT_W   = $clog2(SLOTS);
    localparam int SUB_W   = 6;

    // bit s holds the clock lane level in slot s
    localparam logic [SLOTS-1:0] CLK_LANE_PATTERN = 7'b1100011;

    typedef enum logic [1:0] {
        MAP_NARROW18   = 2'b00,
        MAP_WIDE_MSB   = 2'b01,
        MAP_WIDE_EXT   = 2'b10,
        MAP_NARROW_ALT = 2'b11
    } map_e;

    typedef struct packed {
        logic [COLOR_W-1:0] red;
        logic [COLOR_W-1:0] green;
        logic [COLOR_W-1:0] blue;
        logic               hsync;
        logic               vsync;
        logic               de;
    } pixel_t;

    typedef logic [SLOTS-1:0]            lane_word_t;
    typedef lane_word_t [LANES-1:0]      lane_bundle_t;

    typedef struct packed {
        logic [SUB_W-1:0] r;
        logic [SUB_W-1:0] g;
        logic [SUB_W-1:0] b;
    } sub_color_t;

    function automatic logic map_is_narrow(map_e m);
        return (m == MAP_NARROW18) || (m == MAP_NARROW_ALT);
    endfunction

    // bit index of a lane word equals the slot number
    function automatic lane_word_t base_lane0(sub_color_t c);
        return {c.r[0], c.r[1], c.r[2], c.r[3], c.r[4], c.r[5], c.g[0]};
    endfunction

    function automatic lane_word_t base_lane1(sub_color_t c);
        return {c.g[1], c.g[2], c.g[3], c.g[4], c.g[5], c.b[0], c.b[1]};
    endfunction

    function automatic lane_word_t base_lane2(sub_color_t c, pixel_t p);
        return {c.b[2], c.b[3], c.b[4], c.b[5], p.hsync, p.vsync, p.de};
    endfunction

endpackage

// File: rtl/ser_slot_counter.sv
module ser_slot_counter #(
    parameter int SLOTS = lvds_ser_pkg::SLOTS,
    localparam int CNT_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] slot,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);

    logic [CNT_W-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (slot_q == LAST) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_q + CNT_W'(1);
        end
    end

    assign slot = slot_q;
    assign wrap = (slot_q == LAST);

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
        slot_q <= LAST);                                            // R1
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        (slot_q != LAST) |=> (slot_q == $past(slot_q) + CNT_W'(1))); // R1
    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (slot_q == LAST) |=> (slot_q == '0));                       // R1

endmodule

// File: rtl/ser_pixel_shadow.sv
module ser_pixel_shadow
    import lvds_ser_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wrap,
    input  pixel_t pix_in,
    input  map_e   map_in,
    output pixel_t pix_q,
    output map_e   map_q,
    output logic   loaded
);
    pixel_t pix_r;
    map_e   map_r;
    logic   loaded_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_r    <= '0;
            map_r    <= MAP_NARROW18;
            loaded_r <= 1'b0;
        end else if (wrap) begin
            pix_r    <= pix_in;
            map_r    <= map_in;
            loaded_r <= 1'b1;
        end
    end

    assign pix_q  = pix_r;
    assign map_q  = map_r;
    assign loaded = loaded_r;

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> ($stable(pix_r) && $stable(map_r)));              // R4
    AST_LOAD_STICKY: assert property (@(posedge clk) disable iff (rst)
        loaded_r |=> loaded_r);                                     // R2

endmodule

// File: rtl/ser_lane_mapper.sv
module ser_lane_mapper
    import lvds_ser_pkg::*;
(
    input  pixel_t       pix,
    input  map_e         map,
    input  logic         loaded,
    output lane_bundle_t lanes
);
    sub_color_t   upper;
    sub_color_t   lower;
    sub_color_t   sel;
    lane_bundle_t raw;

    always_comb begin
        upper.r = pix.red[COLOR_W-1 -: SUB_W];
        upper.g = pix.green[COLOR_W-1 -: SUB_W];
        upper.b = pix.blue[COLOR_W-1 -: SUB_W];
        lower.r = pix.red[SUB_W-1:0];
        lower.g = pix.green[SUB_W-1:0];
        lower.b = pix.blue[SUB_W-1:0];
        sel     = (map == MAP_WIDE_EXT) ? lower : upper;
    end

    always_comb begin
        raw[0] = base_lane0(sel);
        raw[1] = base_lane1(sel);
        raw[2] = base_lane2(sel, pix);
        unique case (map)
            MAP_WIDE_MSB:
                raw[3] = {pix.red[0], pix.red[1], pix.green[0], pix.green[1],
                          pix.blue[0], pix.blue[1], 1'b0};
            MAP_WIDE_EXT:
                raw[3] = {pix.red[6], pix.red[7], pix.green[6], pix.green[7],
                          pix.blue[6], pix.blue[7], 1'b0};
            default:
                raw[3] = '0;
        endcase
    end

    assign lanes = loaded ? raw : '0;

    always_comb begin
        assert (map_is_narrow(map) -> (lanes[3] == '0));           // R7
        assert (lanes[3][0] == 1'b0);                               // R10
    end

endmodule

// File: rtl/ser_lane_driver.sv
module ser_lane_driver
    import lvds_ser_pkg::*;
#(
    parameter int NLANES = LANES,
    parameter int NSLOTS = SLOTS,
    localparam int SW = $clog2(NSLOTS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [SW-1:0]                 slot,
    input  logic [NLANES-1:0][NSLOTS-1:0] lanes,
    input  logic [NSLOTS-1:0]             clk_pattern,
    output logic [NLANES-1:0]             lane_dat,
    output logic                          lane_clk
);
    logic [NLANES-1:0] next_bits;
    logic [NLANES-1:0] dat_q;
    logic              clk_q;

    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        assign next_bits[i] = lanes[i][slot];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dat_q <= '0;
            clk_q <= 1'b0;
        end else begin
            dat_q <= next_bits;
            clk_q <= clk_pattern[slot];
        end
    end

    assign lane_dat = dat_q;
    assign lane_clk = clk_q;

    AST_CLK_LOW_RUN: assert property (@(posedge clk) disable iff (rst)
        ($fell(clk_q) && !$past(rst)) |=> !clk_q);                  // R1
    AST_CLK_HIGH_ROSE: assert property (@(posedge clk) disable iff (rst)
        ($rose(clk_q) && !$past(rst) && !$past(rst, 2)) |=> clk_q); // R1

endmodule

// File: rtl/lvds_pixel_serializer.sv
module lvds_pixel_serializer
    import lvds_ser_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [COLOR_W-1:0] pix_red,
    input  logic [COLOR_W-1:0] pix_green,
    input  logic [COLOR_W-1:0] pix_blue,
    input  logic               pix_hsync,
    input  logic               pix_vsync,
    input  logic               pix_de,
    input  logic [1:0]         map_sel,
    output logic [LANES-1:0]   lane_dat,
    output logic               lane_clk
);
    logic [CNT_W-1:0] slot;
    logic             wrap;
    pixel_t           pix_in;
    pixel_t           pix_q;
    map_e             map_q;
    logic             loaded;
    lane_bundle_t     lanes;

    always_comb begin
        pix_in.red   = pix_red;
        pix_in.green = pix_green;
        pix_in.blue  = pix_blue;
        pix_in.hsync = pix_hsync;
        pix_in.vsync = pix_vsync;
        pix_in.de    = pix_de;
    end

    ser_slot_counter #(.SLOTS(SLOTS)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .slot (slot),
        .wrap (wrap)
    );

    ser_pixel_shadow u_shadow (
        .clk    (clk),
        .rst    (rst),
        .wrap   (wrap),
        .pix_in (pix_in),
        .map_in (map_e'(map_sel)),
        .pix_q  (pix_q),
        .map_q  (map_q),
        .loaded (loaded)
    );

    ser_lane_mapper u_map (
        .pix    (pix_q),
        .map    (map_q),
        .loaded (loaded),
        .lanes  (lanes)
    );

    ser_lane_driver #(.NLANES(LANES), .NSLOTS(SLOTS)) u_drv (
        .clk         (clk),
        .rst         (rst),
        .slot        (slot),
        .lanes       (lanes),
        .clk_pattern (CLK_LANE_PATTERN),
        .lane_dat    (lane_dat),
        .lane_clk    (lane_clk)
    );

    AST_EMPTY_BEFORE_LOAD: assert property (@(posedge clk) disable iff (rst)
        !loaded |=> (lane_dat == '0));                              // R2
    AST_LANE3_IDLE: assert property (@(posedge clk) disable iff (rst)
        map_is_narrow(map_q) |=> (lane_dat[3] == 1'b0));            // R7
    AST_CTL3_ZERO: assert property (@(posedge clk) disable iff (rst)
        (slot == '0) |=> (lane_dat[3] == 1'b0));                    // R10
    AST_CLK_SLOT0_HIGH: assert property (@(posedge clk) disable iff (rst)
        (slot == '0) |=> lane_clk);                                 // R1

endmodule

// File: tb/tb_lvds_pixel_serializer.sv
module tb_lvds_pixel_serializer;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] pix_red, pix_green, pix_blue;
    logic       pix_hsync, pix_vsync, pix_de;
    logic [1:0] map_sel;
    logic [3:0] lane_dat;
    logic       lane_clk;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    logic [3:0] prev_slot6;
    string      prev_req;

    always #4 clk = ~clk;

    lvds_pixel_serializer dut (
        .clk       (clk),
        .rst       (rst),
        .pix_red   (pix_red),
        .pix_green (pix_green),
        .pix_blue  (pix_blue),
        .pix_hsync (pix_hsync),
        .pix_vsync (pix_vsync),
        .pix_de    (pix_de),
        .map_sel   (map_sel),
        .lane_dat  (lane_dat),
        .lane_clk  (lane_clk)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    function automatic logic clk_exp(input int s);
        return (s == 0) || (s == 1) || (s == 5) || (s == 6);
    endfunction

    // expected lanes {l3,l2,l1,l0} for slot s (R5, R6, R7, R8, R9, R10)
    function automatic logic [3:0] exp_slot(input logic [1:0] m, input int s,
            input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
            input logic hs, input logic vs, input logic de);
        logic [5:0] R6, G6, B6;
        logic l0, l1, l2, l3;
        if (m == 2'b10) begin
            R6 = r[5:0]; G6 = g[5:0]; B6 = b[5:0];
        end else begin
            R6 = r[7:2]; G6 = g[7:2]; B6 = b[7:2];
        end
        case (s)
            0: begin l0 = G6[0]; l1 = B6[1]; l2 = de;    end
            1: begin l0 = R6[5]; l1 = B6[0]; l2 = vs;    end
            2: begin l0 = R6[4]; l1 = G6[5]; l2 = hs;    end
            3: begin l0 = R6[3]; l1 = G6[4]; l2 = B6[5]; end
            4: begin l0 = R6[2]; l1 = G6[3]; l2 = B6[4]; end
            5: begin l0 = R6[1]; l1 = G6[2]; l2 = B6[3]; end
            default: begin l0 = R6[0]; l1 = G6[1]; l2 = B6[2]; end
        endcase
        l3 = 1'b0;
        if (m == 2'b01) begin
            case (s)
                1: l3 = b[1]; 2: l3 = b[0]; 3: l3 = g[1];
                4: l3 = g[0]; 5: l3 = r[1]; 6: l3 = r[0];
                default: l3 = 1'b0;
            endcase
        end else if (m == 2'b10) begin
            case (s)
                1: l3 = b[7]; 2: l3 = b[6]; 3: l3 = g[7];
                4: l3 = g[6]; 5: l3 = r[7]; 6: l3 = r[6];
                default: l3 = 1'b0;
            endcase
        end
        return {l3, l2, l1, l0};
    endfunction

    // R3: inputs driven before a capture edge; slot s shows after edge C+1+s
    task automatic send_pix(input logic [1:0] m, input logic [7:0] r,
            input logic [7:0] g, input logic [7:0] b, input logic hs,
            input logic vs, input logic de, input bit disturb, input string req);
        logic [3:0] exp [7];
        for (int s = 0; s < 7; s++) exp[s] = exp_slot(m, s, r, g, b, hs, vs, de);
        map_sel = m; pix_red = r; pix_green = g; pix_blue = b;
        pix_hsync = hs; pix_vsync = vs; pix_de = de;
        step();
        check(prev_req, "slot6 data", lane_dat, prev_slot6);
        check("R1", "slot6 clk", {3'b0, lane_clk}, {3'b0, clk_exp(6)});
        for (int s = 0; s < 6; s++) begin
            if (disturb && s == 2) begin
                // R4: mid-word changes must not reach the lanes
                map_sel = ~m; pix_red = ~r; pix_green = ~g; pix_blue = ~b;
                pix_hsync = ~hs; pix_vsync = ~vs; pix_de = ~de;
            end
            step();
            check(disturb ? "R4" : req, $sformatf("slot%0d data", s), lane_dat, exp[s]);
            check("R1", $sformatf("slot%0d clk", s), {3'b0, lane_clk}, {3'b0, clk_exp(s)});
        end
        prev_slot6 = exp[6];
        prev_req   = disturb ? "R4" : req;
    endtask

    task automatic test_reset();
        rst = 1'b1;
        map_sel = 2'b00; pix_red = 8'hFF; pix_green = 8'hFF; pix_blue = 8'hFF;
        pix_hsync = 1'b1; pix_vsync = 1'b1; pix_de = 1'b1;
        repeat (3) step();
        check("R2", "reset data", lane_dat, 4'b0);
        check("R2", "reset clk", {3'b0, lane_clk}, 4'b0);
        rst = 1'b0;
        for (int s = 0; s < 6; s++) begin
            step();
            check("R2", $sformatf("pre-load slot%0d data", s), lane_dat, 4'b0);
            check("R1", $sformatf("pre-load slot%0d clk", s), {3'b0, lane_clk}, {3'b0, clk_exp(s)});
        end
        prev_slot6 = 4'b0;
        prev_req   = "R2";
    endtask

    task automatic test_narrow();
        send_pix(2'b00, 8'hA4, 8'h5C, 8'hF0, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
        send_pix(2'b00, 8'h84, 8'h08, 8'h10, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
        // R7: only the ignored low bits change, lanes must equal the zero-low pixel
        send_pix(2'b00, 8'h87, 8'h0B, 8'h13, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
        send_pix(2'b00, 8'h03, 8'h03, 8'h03, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    endtask

    task automatic test_wide_msb();
        send_pix(2'b01, 8'hC3, 8'h5A, 8'h96, 1'b0, 1'b1, 1'b1, 1'b0, "R8");
        send_pix(2'b01, 8'h01, 8'h02, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
        send_pix(2'b01, 8'hFF, 8'h00, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, "R8");
    endtask

    task automatic test_wide_ext();
        send_pix(2'b10, 8'hC3, 8'h5A, 8'h96, 1'b0, 1'b1, 1'b1, 1'b0, "R9");
        send_pix(2'b10, 8'h40, 8'h80, 8'h21, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
    endtask

    task automatic test_alt_code();
        send_pix(2'b11, 8'hC3, 8'h5A, 8'h96, 1'b0, 1'b1, 1'b1, 1'b0, "R5");
    endtask

    task automatic test_controls();
        send_pix(2'b01, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R10");
        send_pix(2'b10, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, "R10");
        send_pix(2'b00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, "R10");
    endtask

    task automatic test_midword_change();
        send_pix(2'b01, 8'h3C, 8'hE1, 8'h0F, 1'b1, 1'b0, 1'b1, 1'b1, "R4");
        send_pix(2'b00, 8'h3C, 8'hE1, 8'h0F, 1'b0, 1'b1, 1'b0, 1'b1, "R4");
        // R3: the mode change made mid-word takes effect on the next pixel
        send_pix(2'b10, 8'h3C, 8'hE1, 8'h0F, 1'b0, 1'b0, 1'b1, 1'b0, "R3");
    endtask

    initial begin
        test_reset();
        test_narrow();
        test_wide_msb();
        test_wide_ext();
        test_alt_code();
        test_controls();
        test_midword_change();
        step();
        check(prev_req, "final slot6 data", lane_dat, prev_slot6);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule